// File: doc/BRIEF.md
# Rate-1/3 Convolutional Encoder with Triplet Streams

This block turns a stream of information bits into a stream of coded bits at one third of the rate. It accepts one information bit per handshake and keeps the six most recent inputs in a shift register, which gives 64 states and constraint length 7. For each accepted bit it forms three parity bits from three fixed generator polynomials. The three bits of one time step form a triplet.

Each triplet leaves the block on two ports. The parallel port carries all three bits in one beat, with each bit on its own lane, so later logic can send each stream to a different frequency band. The serial port sends the same triplet one bit at a time. A triplet is released only after both ports have taken it, so a stall on either port holds the input.

A block-start strobe clears the code memory so that each packet begins from state zero. When trellis termination is requested, the block appends six zero-input steps after the last data bit of a block. The coded outputs of those steps are emitted in the normal way.

Top module: `conv3_encoder`

## Requirements
- R1: The window is {u, s5..s0}, where u is the current input, s5 is the previous input and s0 is the input six steps back. Generator bit 6 (the octal MSB) taps u, and bit k for k below 6 taps s(k). The lane bits are b0 = parity(window & 117 octal), b1 = parity(window & 155 octal) and b2 = parity(window & 127 octal). Lane b_i is par_bits[i].
- R2: Every accepted input bit produces exactly one triplet on the parallel port, in the order of acceptance. No triplet is lost, repeated or added.
- R3: The serial port emits b0, b1 and b2 of time t, then b0, b1 and b2 of time t+1, and so on.
- R4: An input bit accepted with blk_start high is encoded from an all-zero state. A blk_start pulse with no accepted bit clears the state, so the next bit is also encoded from zero.
- R5: When an input bit is accepted with in_last and tail_en both high, six zero-input triplets follow it. in_ready stays low from the cycle after that acceptance until the six steps have been loaded.
- R6: When an input bit is accepted with in_last high and tail_en low, no extra triplets follow and the encoder takes new input at once.
- R7: While a port is valid and its ready is low, its valid stays high and its data stays unchanged on the next cycle.
- R8: After reset, par_valid and ser_valid are low, in_ready is high and the state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Encoder accepts the input bit this cycle |
| in_bit | input | 1 | Information bit |
| blk_start | input | 1 | Clears the code memory; when it comes with an accepted bit, that bit starts from zero state |
| in_last | input | 1 | Marks the last data bit of a block |
| tail_en | input | 1 | With in_last, appends six zero-input steps |
| par_valid | output | 1 | Parallel triplet is valid |
| par_ready | input | 1 | Parallel consumer takes the triplet |
| par_bits | output | NOUT | Triplet; bit i is lane b_i |
| ser_valid | output | 1 | Serial bit is valid |
| ser_ready | input | 1 | Serial consumer takes the bit |
| ser_bit | output | 1 | Serialized coded bit |

## Verification
The bench builds the encoder with its default parameters: constraint length 7, three lanes and the generators 117, 155 and 127 octal. These defaults make the exact state count, the six-step tail and the three-bit serial cadence observable at the ports. Blocks are run with both readies held high and with both readies toggled at random and independently. This exercises stalls on one port while the other runs ahead, tails that collide with stalls, a lone blk_start between blocks, and a block that starts right after a flushed one.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  localparam int CONSTR_LEN = 7;
  localparam int NUM_LANES  = 3;
  // lane 0 first: 117, 155, 127 (octal)
  localparam logic [NUM_LANES-1:0][CONSTR_LEN-1:0] DEF_GENS =
    {7'o127, 7'o155, 7'o117};
endpackage

// File: rtl/conv3_state.sv
module conv3_state #(
  parameter int STATE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               clear,
  input  logic               u,
  output logic [STATE_W-1:0] cur,
  output logic [STATE_W-1:0] state_q
);
  // top bit holds the newest past input, bit 0 the oldest
  assign cur = clear ? '0 : state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (load) begin
      state_q <= {u, cur[STATE_W-1:1]};
    end else if (clear) begin
      state_q <= '0;
    end
  end
endmodule

// File: rtl/conv3_taps.sv
module conv3_taps #(
  parameter int K    = 7,
  parameter int NOUT = 3,
  parameter logic [NOUT-1:0][K-1:0] GENS = conv3_pkg::DEF_GENS
) (
  input  logic            u,
  input  logic [K-2:0]    cur,
  output logic [NOUT-1:0] code
);
  logic [K-1:0] window;
  assign window = {u, cur};

  for (genvar g = 0; g < NOUT; g++) begin : g_lane
    assign code[g] = ^(window & GENS[g]);
  end
endmodule

// File: rtl/conv3_tailctl.sv
module conv3_tailctl #(
  parameter int TAIL_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic in_fire,
  input  logic in_last,
  input  logic tail_en,
  input  logic step,
  output logic flushing
);
  localparam int CW = $clog2(TAIL_LEN + 1);
  logic [CW-1:0] left_q;

  assign flushing = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (in_fire && in_last && tail_en) begin
      left_q <= CW'(TAIL_LEN);
    end else if (step && flushing) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/conv3_outstage.sv
module conv3_outstage #(
  parameter int NOUT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [NOUT-1:0] trip_in,
  output logic            free,
  output logic            par_valid,
  input  logic            par_ready,
  output logic [NOUT-1:0] par_bits,
  output logic            ser_valid,
  input  logic            ser_ready,
  output logic            ser_bit
);
  localparam int IW = $clog2(NOUT + 1);

  logic [NOUT-1:0] data_q;
  logic            full_q;
  logic            par_pend_q;
  logic [IW-1:0]   idx_q;
  logic            par_fire, ser_fire, par_done, ser_done, retire;

  assign par_valid = full_q && par_pend_q;
  assign ser_valid = full_q && (idx_q < IW'(NOUT));
  assign par_bits  = data_q;
  assign par_fire  = par_valid && par_ready;
  assign ser_fire  = ser_valid && ser_ready;

  always_comb begin
    ser_bit = 1'b0;
    for (int i = 0; i < NOUT; i++) begin
      if (idx_q == IW'(i)) ser_bit = data_q[i];
    end
  end

  assign par_done = !par_pend_q || par_fire;
  assign ser_done = (idx_q == IW'(NOUT)) || (ser_fire && idx_q == IW'(NOUT - 1));
  assign retire   = full_q && par_done && ser_done;
  assign free     = !full_q || retire;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      full_q     <= 1'b0;
      par_pend_q <= 1'b0;
      idx_q      <= '0;
    end else if (load) begin
      data_q     <= trip_in;
      full_q     <= 1'b1;
      par_pend_q <= 1'b1;
      idx_q      <= '0;
    end else if (retire) begin
      full_q     <= 1'b0;
      par_pend_q <= 1'b0;
    end else begin
      if (par_fire) par_pend_q <= 1'b0;
      if (ser_fire) idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/conv3_encoder.sv
module conv3_encoder #(
  parameter int K    = conv3_pkg::CONSTR_LEN,
  parameter int NOUT = conv3_pkg::NUM_LANES,
  parameter logic [NOUT-1:0][K-1:0] GENS = conv3_pkg::DEF_GENS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_bit,
  input  logic            blk_start,
  input  logic            in_last,
  input  logic            tail_en,
  output logic            par_valid,
  input  logic            par_ready,
  output logic [NOUT-1:0] par_bits,
  output logic            ser_valid,
  input  logic            ser_ready,
  output logic            ser_bit
);
  localparam int STATE_W  = K - 1;
  localparam int TAIL_LEN = STATE_W;

  logic               flushing, free, load, in_fire, start_eff, src_bit;
  logic [STATE_W-1:0] cur, state_q;
  logic [NOUT-1:0]    code;

  assign in_ready  = !flushing && free;
  assign in_fire   = in_valid && in_ready;
  assign load      = free && (flushing || in_valid);
  assign src_bit   = flushing ? 1'b0 : in_bit;
  assign start_eff = blk_start && !flushing;

  conv3_state #(.STATE_W(STATE_W)) u_state (
    .clk(clk), .rst(rst), .load(load), .clear(start_eff), .u(src_bit),
    .cur(cur), .state_q(state_q)
  );

  conv3_taps #(.K(K), .NOUT(NOUT), .GENS(GENS)) u_taps (
    .u(src_bit), .cur(cur), .code(code)
  );

  conv3_tailctl #(.TAIL_LEN(TAIL_LEN)) u_tail (
    .clk(clk), .rst(rst), .in_fire(in_fire), .in_last(in_last),
    .tail_en(tail_en), .step(load), .flushing(flushing)
  );

  conv3_outstage #(.NOUT(NOUT)) u_out (
    .clk(clk), .rst(rst), .load(load), .trip_in(code), .free(free),
    .par_valid(par_valid), .par_ready(par_ready), .par_bits(par_bits),
    .ser_valid(ser_valid), .ser_ready(ser_ready), .ser_bit(ser_bit)
  );
endmodule

// File: rtl/conv3_encoder_chk.sv
module conv3_encoder_chk #(
  parameter int NOUT    = 3,
  parameter int STATE_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_bit,
  input logic               blk_start,
  input logic               flushing,
  input logic [STATE_W-1:0] state_q,
  input logic               par_valid,
  input logic               par_ready,
  input logic [NOUT-1:0]    par_bits,
  input logic               ser_valid,
  input logic               ser_ready,
  input logic               ser_bit
);
  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    par_valid && !par_ready |=> par_valid && $stable(par_bits)); // R7
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (rst)
    ser_valid && !ser_ready |=> ser_valid && $stable(ser_bit)); // R7
  AST_FLUSH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    flushing |-> !in_ready); // R5
  AST_LONE_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    blk_start && !flushing && !(in_valid && in_ready) |=> state_q == '0); // R4
  AST_START_BIT_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    blk_start && in_valid && in_ready |=>
      state_q[STATE_W-1] == $past(in_bit) && state_q[STATE_W-2:0] == '0); // R4
endmodule

bind conv3_encoder conv3_encoder_chk #(.NOUT(NOUT), .STATE_W(STATE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_bit(in_bit), .blk_start(blk_start), .flushing(flushing),
  .state_q(state_q), .par_valid(par_valid), .par_ready(par_ready),
  .par_bits(par_bits), .ser_valid(ser_valid), .ser_ready(ser_ready),
  .ser_bit(ser_bit)
);

// File: tb/sim_conv3_encoder.sv
`timescale 1ns/1ps
module sim_conv3_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, blk_start = 1'b0, in_last = 1'b0, tail_en = 1'b0;
  logic par_ready = 1'b1, ser_ready = 1'b1;
  logic in_ready, par_valid, ser_valid, ser_bit;
  logic [2:0] par_bits;

  int errors = 0;
  int checks = 0;
  int rmode = 0;
  logic [5:0] ref_st = '0;
  logic [2:0] par_q[$];
  logic       ser_q[$];

  always #10 clk = ~clk;

  conv3_encoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .blk_start(blk_start), .in_last(in_last),
    .tail_en(tail_en), .par_valid(par_valid), .par_ready(par_ready),
    .par_bits(par_bits), .ser_valid(ser_valid), .ser_ready(ser_ready),
    .ser_bit(ser_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: taps per requirement, window {u, s5..s0}
  function automatic logic [2:0] enc(input logic u, input logic [5:0] s);
    logic [6:0] w;
    w = {u, s};
    enc[0] = ^(w & 7'o117);
    enc[1] = ^(w & 7'o155);
    enc[2] = ^(w & 7'o127);
  endfunction

  task automatic push_step(input logic u);
    logic [2:0] t;
    t = enc(u, ref_st);
    par_q.push_back(t);
    ser_q.push_back(t[0]); ser_q.push_back(t[1]); ser_q.push_back(t[2]);
    ref_st = {u, ref_st[5:1]};
  endtask

  task automatic send(input logic b, input logic st, input logic last, input logic tl);
    bit acc;
    if (st) ref_st = '0;
    push_step(b);
    if (last && tl) for (int i = 0; i < 6; i++) push_step(1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; blk_start = st; in_last = last; tail_en = tl;
    do begin
      #1 acc = in_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end while (!acc);
    #1;
    in_valid = 1'b0; blk_start = 1'b0; in_last = 1'b0; tail_en = 1'b0;
    if (last && tl) check(in_ready == 1'b0, "R5 in_ready during tail", in_ready, 0);
  endtask

  task automatic lone_start();
    @(negedge clk);
    blk_start = 1'b1;
    @(posedge clk);
    #1 blk_start = 1'b0;
    ref_st = '0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((par_q.size() != 0 || ser_q.size() != 0) && n < 3000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
    #3;
    check(par_q.size() == 0 && ser_q.size() == 0, req, par_q.size() + ser_q.size(), 0);
    check(!par_valid && !ser_valid, req, int'(par_valid) + int'(ser_valid), 0);
    check(in_ready == 1'b1, req, in_ready, 1);
  endtask

  always @(negedge clk) begin
    par_ready <= (rmode == 0) ? 1'b1 : ($urandom % 4 != 0);
    ser_ready <= (rmode == 0) ? 1'b1 : ($urandom % 3 != 0);
  end

  // scoreboard monitor
  logic       par_stall = 1'b0, ser_stall = 1'b0;
  logic [2:0] par_prev = '0;
  logic       ser_prev = 1'b0;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (par_stall) check(par_valid && par_bits == par_prev, "R7 parallel hold", par_bits, par_prev);
      if (ser_stall) check(ser_valid && ser_bit == ser_prev, "R7 serial hold", ser_bit, ser_prev);
      if (par_valid && par_ready) begin
        if (par_q.size() == 0) check(1'b0, "R2 extra triplet", par_bits, -1);
        else begin
          logic [2:0] e;
          e = par_q.pop_front();
          check(par_bits == e, "R1 R2 triplet", par_bits, e);
        end
      end
      if (ser_valid && ser_ready) begin
        if (ser_q.size() == 0) check(1'b0, "R3 extra serial bit", ser_bit, -1);
        else begin
          logic e;
          e = ser_q.pop_front();
          check(ser_bit == e, "R3 serial order", ser_bit, e);
        end
      end
      par_stall = par_valid && !par_ready; par_prev = par_bits;
      ser_stall = ser_valid && !ser_ready; ser_prev = ser_bit;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #3;
    check(!par_valid && !ser_valid, "R8 reset outputs", int'(par_valid) + int'(ser_valid), 0);
    check(in_ready == 1'b1, "R8 reset ready", in_ready, 1);

    // R1 impulse from zero state, then tail (R5), readies high
    send(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) send(i[0] ^ i[2], 1'b0, (i == 9), 1'b1);
    drain("R5 tail drained");

    // random data, stalling ports, no tail (R6, R7)
    rmode = 1;
    for (int i = 0; i < 40; i++) send(1'($urandom), (i == 0), (i == 39), 1'b0);
    drain("R6 no tail steps");

    // lone start between bits (R4)
    for (int i = 0; i < 5; i++) send(1'b1, 1'b0, 1'b0, 1'b0);
    lone_start();
    for (int i = 0; i < 12; i++) send(1'($urandom), 1'b0, (i == 11), 1'b1);
    // back-to-back: new block straight after a tailed one
    for (int i = 0; i < 30; i++) send(1'($urandom), (i == 0), (i == 29), 1'b1);
    drain("R4 R5 restart");

    rmode = 0;
    for (int i = 0; i < 16; i++) send(1'($urandom), (i == 0), (i == 15), (i < 0));
    drain("R2 R6 final");
    finish_run();
  end
endmodule